// File: doc/BRIEF.md
# Timer Capture/Compare Unit

This block pairs a free-running 16-bit timer with one 16-bit capture/compare register. A 4-bit mode field selects what the register does. It can stay idle. It can latch the timer value when the input pin shows a chosen edge, with an optional edge prescaler. It can also act as a compare register that is checked against the timer on every clock. On a match the unit drives the output pin high, drives it low, only raises an interrupt, or fires a special event.

The special event clears the timer, so the compare register becomes a programmable period. The same event emits a one-cycle start pulse for an external converter. Software reaches the unit through a narrow write port of 8-bit words. Address 0 holds the mode. Address 1 holds the low byte of the compare register and address 2 the high byte. A write to address 3 clears flags. The timer value and the capture/compare register are visible as outputs.

Top module: `capcmp_unit`

## Requirements
- R1: Leaving reset, the timer advances by one on every clock. When it rolls over from FFFF to 0000 by itself, the overflow flag becomes 1 on that same edge.
- R2: Mode 1000 is compare set-high. When the timer equals the compare register, the next edge sets the output to 1 and sets the interrupt flag.
- R3: Mode 1001 is compare set-low. A match drives the output to 0 on the next edge and sets the interrupt flag.
- R4: Mode 1010 is compare interrupt-only. A match sets the interrupt flag and never changes the output.
- R5: Mode 1011 is compare special event. On a match the next edge loads the timer with 0 and raises the converter-start output for exactly one cycle. That reload never sets the overflow flag, not even when it happens at FFFF. The period is therefore the compare value plus one.
- R6: Writing 0000 to the mode field (address 0, data bits 3:0) forces the output to 0 on the next edge. This overrides a match in the same cycle.
- R7: Modes 0100 and 0101 are capture on every falling edge and capture on every rising edge. The pin passes through a two-flop synchronizer. The selected edge copies the timer into the register two clocks after the first edge at which the new pin level is sampled, and it sets the interrupt flag. The other edge direction does nothing.
- R8: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th, counted from the moment the unit enters capture from a non-capture mode.
- R9: The edge counter counts rising edges in every capture mode. It is cleared only while the mode is not a capture mode. A change between capture settings keeps the count, so the first capture after the change can come early.
- R10: Write addresses: 1 loads compare bits 7:0, 2 loads bits 15:8, and 3 clears flags (data bit 0 clears the interrupt flag, bit 1 clears the overflow flag). Each clear affects only its own flag.
- R11: Reset (rst_n low, asynchronous) sets the timer, the register, the mode, the output, both flags and the converter-start output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 compare low, 2 compare high, 3 flag clear |
| wr_data | input | 8 | Write data |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_out | output | 1 | Compare output latch |
| irq_flag | output | 1 | Unit interrupt flag |
| ovf_flag | output | 1 | Timer overflow flag |
| adc_start | output | 1 | One-cycle converter start pulse |
| timer_val | output | 16 | Current timer value |
| ccr_val | output | 16 | Capture/compare register |

## Verification
The assertions check on every cycle that the timer steps by one unless a special event has just reloaded it, and that such a reload leaves it at zero. They also check that the start pulse never lasts two cycles for a nonzero period, that a natural rollover raises the overflow flag, that interrupt-only mode keeps the pin still, and that clearing the mode drops the pin. Some behaviours need a history of stimulus and only the bench scenarios can show them: capture latency through the synchronizer, the prescaler counts, the edge count that survives a change of prescaler, and a special event at FFFF that must not be mistaken for an overflow.

// File: rtl/capcmp_unit.sv
module capcmp_unit #(
  parameter int DW = 8,
  parameter int PSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            cap_pin,
  output logic            cmp_out,
  output logic            irq_flag,
  output logic            ovf_flag,
  output logic            adc_start,
  output logic [2*DW-1:0] timer_val,
  output logic [2*DW-1:0] ccr_val
);
  localparam int TW = 2 * DW;

  logic [3:0]     mode_q;
  logic [TW-1:0]  tmr_q, ccr_q;
  logic [2:0]     sync_q;
  logic [PSW-1:0] ecnt_q;
  logic           out_q, irq_q, ovf_q, trig_q;
  logic           cap_hit;

  wire wr_mode = wr_en && wr_addr == 2'd0;
  wire wr_lo   = wr_en && wr_addr == 2'd1;
  wire wr_hi   = wr_en && wr_addr == 2'd2;
  wire wr_clr  = wr_en && wr_addr == 2'd3;
  wire in_cap  = mode_q[3:2] == 2'b01;
  wire hit     = mode_q[3:2] == 2'b10 && tmr_q == ccr_q;
  wire sev_hit = hit && mode_q[1:0] == 2'b11;
  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];

  always_comb begin
    case (mode_q[1:0])
      2'd0:    cap_hit = fall;
      2'd1:    cap_hit = rise;
      2'd2:    cap_hit = rise && ecnt_q[1:0] == 2'b11;
      default: cap_hit = rise && ecnt_q == '1;
    endcase
    cap_hit = cap_hit && in_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; tmr_q <= '0; ccr_q <= '0; sync_q <= '0; ecnt_q <= '0;
      out_q <= 1'b0; irq_q <= 1'b0; ovf_q <= 1'b0; trig_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], cap_pin};
      trig_q <= sev_hit;
      tmr_q  <= sev_hit ? '0 : tmr_q + TW'(1);
      if (wr_mode) mode_q <= wr_data[3:0];

      if (!in_cap)   ecnt_q <= '0;
      else if (rise) ecnt_q <= ecnt_q + PSW'(1);

      if (cap_hit)    ccr_q <= tmr_q;
      else if (wr_lo) ccr_q[DW-1:0] <= wr_data;
      else if (wr_hi) ccr_q[TW-1:DW] <= wr_data;

      if (wr_mode && wr_data[3:0] == 4'd0)     out_q <= 1'b0;
      else if (hit && mode_q[1:0] == 2'b00)    out_q <= 1'b1;
      else if (hit && mode_q[1:0] == 2'b01)    out_q <= 1'b0;

      if (hit || cap_hit)         irq_q <= 1'b1;
      else if (wr_clr && wr_data[0]) irq_q <= 1'b0;

      if (tmr_q == '1 && !sev_hit)   ovf_q <= 1'b1;
      else if (wr_clr && wr_data[1]) ovf_q <= 1'b0;
    end
  end

  assign cmp_out   = out_q;
  assign irq_flag  = irq_q;
  assign ovf_flag  = ovf_q;
  assign adc_start = trig_q;
  assign timer_val = tmr_q;
  assign ccr_val   = ccr_q;

  p_timer_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q != '1 |=> (trig_q || tmr_q == $past(tmr_q) + TW'(1)));
  p_wrap_ovf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == '1 && !trig_q) |=> (ovf_q || trig_q));
  p_sev_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> tmr_q == '0);
  p_sev_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && ccr_q != '0) |=> !trig_q);
  p_swi_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'b1010 && !wr_mode) |=> $stable(out_q));
  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wr_data[3:0] == 4'd0) |=> !out_q);
  p_cap_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> irq_q);
endmodule

// File: tb/capcmp_unit_tb_top.sv
module capcmp_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cap_pin = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cmp_out, irq_flag, ovf_flag, adc_start;
  logic [15:0] timer_val, ccr_val;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  capcmp_unit dut_i (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cap_pin,
    .cmp_out, .irq_flag, .ovf_flag, .adc_start, .timer_val, .ccr_val);

  // behavioural reference
  int m_mode = 0, m_tmr = 0, m_ccr = 0, m_cnt = 0;
  bit m_out = 0, m_irq = 0, m_ovf = 0, m_trig = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) if (rst_n) begin
    bit hit, sev, up, dn, cap;
    int n;
    n   = hist.size();
    up  = hist[n-2] && !hist[n-3];
    dn  = !hist[n-2] && hist[n-3];
    hit = (m_mode / 4 == 2) && m_tmr == m_ccr;
    sev = hit && m_mode == 11;
    cap = 0;
    if (m_mode == 4) cap = dn;
    if (m_mode == 5) cap = up;
    if (m_mode == 6) cap = up && (m_cnt % 4 == 3);
    if (m_mode == 7) cap = up && m_cnt == 15;
    m_trig = sev;
    if (wr_en && wr_addr == 0 && wr_data[3:0] == 0) m_out = 0;
    else if (hit && m_mode == 8) m_out = 1;
    else if (hit && m_mode == 9) m_out = 0;
    if (hit || cap) m_irq = 1;
    else if (wr_en && wr_addr == 3 && wr_data[0]) m_irq = 0;
    if (m_tmr == 65535 && !sev) m_ovf = 1;
    else if (wr_en && wr_addr == 3 && wr_data[1]) m_ovf = 0;
    if (m_mode / 4 != 1) m_cnt = 0;
    else if (up) m_cnt = (m_cnt + 1) % 16;
    if (cap) m_ccr = m_tmr;
    else if (wr_en && wr_addr == 1) m_ccr = (m_ccr & 16'hFF00) | wr_data;
    else if (wr_en && wr_addr == 2) m_ccr = (m_ccr & 16'h00FF) | (int'(wr_data) << 8);
    m_tmr = sev ? 0 : (m_tmr + 1) % 65536;
    if (wr_en && wr_addr == 0) m_mode = wr_data[3:0];
    hist.push_back(cap_pin);
    void'(hist.pop_front());
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 timer model", timer_val, m_tmr);
    chk("R1 ovf model", ovf_flag, m_ovf);
    chk("R2 out model", cmp_out, m_out);
    chk("R4 irq model", irq_flag, m_irq);
    chk("R5 adc model", adc_start, m_trig);
    chk("R7 ccr model", ccr_val, m_ccr);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask
  task automatic prog(input int v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask
  task automatic wait_tmr(input int v);
    while (timer_val != v[15:0]) @(negedge clk);
  endtask
  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      cap_pin = 1; repeat (2) @(negedge clk);
      cap_pin = 0; repeat (2) @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    int c, t;
    repeat (3) @(negedge clk);
    chk("R11 timer", timer_val, 0); chk("R11 ccr", ccr_val, 0);
    chk("R11 out", cmp_out, 0); chk("R11 flags", {irq_flag, ovf_flag, adc_start}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 first step", timer_val, 1);

    c = timer_val + 40; prog(c); wr(0, 8'h08);
    wait_tmr(c); chk("R2 before match", cmp_out, 0);
    @(negedge clk); chk("R2 set high", cmp_out, 1); chk("R2 irq", irq_flag, 1);
    wr(3, 8'h01); chk("R10 irq clear", irq_flag, 0); chk("R10 ovf kept", ovf_flag, 0);

    c = timer_val + 40; prog(c); wr(0, 8'h0A); wr(3, 8'h01);
    wait_tmr(c + 1); chk("R4 pin kept", cmp_out, 1); chk("R4 irq", irq_flag, 1);

    c = timer_val + 40; wr(0, 8'h09); prog(c); wr(3, 8'h01);
    wait_tmr(c + 1); chk("R3 set low", cmp_out, 0); chk("R3 irq", irq_flag, 1);

    wr(0, 8'h08); c = timer_val + 40; prog(c);
    wait_tmr(c + 1); chk("R6 precondition", cmp_out, 1);
    wr(0, 8'h00); chk("R6 forced low", cmp_out, 0);

    c = timer_val + 30; prog(c); wr(0, 8'h0B);
    while (!adc_start) @(negedge clk);
    chk("R5 timer zero", timer_val, 0); chk("R5 no ovf", ovf_flag, 0);
    @(negedge clk); chk("R5 one cycle", adc_start, 0);
    t = 1;
    while (!adc_start) begin @(negedge clk); t++; end
    chk("R5 period", t, c + 1);

    wr(0, 8'h05); wr(3, 8'h01);
    t = timer_val; cap_pin = 1; repeat (4) @(negedge clk);
    chk("R7 rise capture", ccr_val, (t + 2) % 65536); chk("R7 irq", irq_flag, 1);
    cap_pin = 0; repeat (3) @(negedge clk);
    wr(0, 8'h04); wr(3, 8'h01); c = ccr_val;
    cap_pin = 1; repeat (5) @(negedge clk);
    chk("R7 rise ignored ccr", ccr_val, c); chk("R7 rise ignored irq", irq_flag, 0);
    t = timer_val; cap_pin = 0; repeat (4) @(negedge clk);
    chk("R7 fall capture", ccr_val, (t + 2) % 65536);

    wr(0, 8'h00); wr(0, 8'h06); wr(3, 8'h01);
    pulses(3); chk("R8 div4 early", irq_flag, 0);
    pulses(1); chk("R8 div4 fourth", irq_flag, 1);
    wr(0, 8'h00); wr(0, 8'h07); wr(3, 8'h01);
    pulses(15); chk("R8 div16 early", irq_flag, 0);
    pulses(1); chk("R8 div16 sixteenth", irq_flag, 1);

    wr(0, 8'h00); wr(0, 8'h07); wr(3, 8'h01);
    pulses(5); wr(0, 8'h06);
    pulses(2); chk("R9 kept count early", irq_flag, 0);
    pulses(1); chk("R9 early capture", irq_flag, 1);
    wr(0, 8'h00); wr(0, 8'h06); wr(3, 8'h01);
    pulses(3); chk("R9 cleared count", irq_flag, 0);
    pulses(1); chk("R9 fourth after off", irq_flag, 1);

    wr(0, 8'h00); prog(16'hFFFF); wr(0, 8'h0B);
    while (!adc_start) @(negedge clk);
    chk("R5 reload at FFFF", timer_val, 0); chk("R5 no ovf at FFFF", ovf_flag, 0);
    wr(0, 8'h0A); wr(3, 8'h01);
    wait_tmr(16'hFFFF); @(negedge clk);
    chk("R1 wrap", timer_val, 0); chk("R1 ovf set", ovf_flag, 1);
    chk("R4 match at FFFF", irq_flag, 1);
    wr(3, 8'h02); chk("R10 ovf clear", ovf_flag, 0); chk("R10 irq kept", irq_flag, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule